// File: doc/BRIEF.md
# Asynchronous Transmit Packet Queue Writer

This block collects outgoing asynchronous packets from a host one 32-bit quadlet per register write. It holds request packets and response packets in two separate transmit FIFOs. The host ends a packet by the address it writes to, not by a length field. Every quadlet except the final one goes to the queue's "append" address. The final quadlet goes to the queue's "close" address. A close write commits the packet at once. The host issues no further command.

A per-queue count tracks packets that are complete and not yet handed on. A queue's packet-ready flag is high while that count is non-zero. A registered output stage offers whole packets to the link's sending logic over a valid/ready handshake, one quadlet per cycle, with an end marker on the final quadlet. The output stage starts a packet only once the packet is fully written into its FIFO. At a packet boundary the response queue goes ahead of the request queue. A packet that has started always runs to its end before another is begun. A host write to a full FIFO is dropped, and a sticky per-queue overflow flag is set.

Top module: `atxq_top`

## Requirements
- R1: Request and response packets travel separately. Address bit 1 selects the queue (0 = request, 1 = response). `tx_is_rsp` is 1 exactly when the offered quadlet came from the response queue. Bit 0 of `pkt_ready` and of `overflow` belongs to the request queue, and bit 1 to the response queue.
- R2: A write with address bit 0 = 0 ("append") stores a quadlet but does not commit a packet. With only append writes pending, `pkt_ready` stays low for that queue and `tx_valid` stays low.
- R3: A write with address bit 0 = 1 ("close") commits the packet. That queue's `pkt_ready` bit is high in the cycle after the write. The first quadlet can appear on `tx_valid` no earlier than the cycle after that.
- R4: Quadlets leave in the order they were written. `tx_last` is 1 only on the quadlet that was written to the close address.
- R5: When the output stage is free at a packet boundary and both queues hold complete packets, the response packet is offered first.
- R6: Once the first quadlet of a packet is offered, all its quadlets are offered back to back. No quadlet of another packet comes between them, even if a response packet is committed meanwhile.
- R7: A host write to a full FIFO is discarded and never appears on the output. It sets that queue's `overflow` bit, which stays set until reset. The other queue's bit is not affected.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_last` and `tx_is_rsp` hold their values.
- R9: After reset, `tx_valid`, `pkt_ready` and `overflow` are all zero. A queue's `pkt_ready` returns to zero once its last committed packet has been passed to the output stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one quadlet per cycle |
| host_addr | input | 2 | Bit 1: queue (0 request, 1 response); bit 0: 0 append, 1 close |
| host_data | input | DATA_W | Quadlet written by the host |
| pkt_ready | output | 2 | Per-queue complete-packet-pending flags |
| overflow | output | 2 | Per-queue sticky write-overflow flags |
| tx_valid | output | 1 | Output quadlet valid |
| tx_ready | input | 1 | Sending logic accepts the quadlet |
| tx_data | output | DATA_W | Output quadlet |
| tx_last | output | 1 | Output quadlet ends its packet |
| tx_is_rsp | output | 1 | Output quadlet belongs to the response queue |

## Verification
A wrong packet count shows up within two cycles in one of two ways. Either `pkt_ready` and `tx_valid` rise on a packet that has no close write, or a closed packet is never offered and the output stays idle. Pointer or end-marker faults show on the very next offered quadlet as wrong data, a misplaced `tx_last`, or a dropped write that reappears after the drain. A lock fault in the output stage shows when a response quadlet turns up inside a request packet. The bench uses packets whose contents encode queue, length and index, so each of these faults gives a mismatch at a known beat.

// File: rtl/atxq_pkg.sv
package atxq_pkg;
  typedef enum logic {
    Q_REQ = 1'b0,
    Q_RSP = 1'b1
  } qid_e;

  localparam int NUM_Q = 2;

  typedef struct packed {
    logic wr;
    logic close;
    qid_e qid;
  } host_cmd_t;
endpackage

// File: rtl/atxq_host_dec.sv
module atxq_host_dec
  import atxq_pkg::*;
(
  input  logic       host_wr,
  input  logic [1:0] host_addr,
  output logic [1:0] q_wr,
  output logic       q_close
);
  host_cmd_t cmd;

  always_comb begin
    cmd.wr    = host_wr;
    cmd.close = host_addr[0];
    cmd.qid   = host_addr[1] ? Q_RSP : Q_REQ;
  end

  always_comb begin
    q_wr = 2'b00;
    if (cmd.wr) q_wr[cmd.qid] = 1'b1;
    q_close = cmd.close;
  end
endmodule

// File: rtl/atxq_fifo.sv
module atxq_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_last,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              empty,
  output logic              full,
  output logic              pkt_avail,
  output logic              overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + 1;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr, level;
  logic [CW-1:0] pcnt;
  logic          wr_ok, rd_ok, inc, dec;

  assign level = wptr - rptr;
  assign full  = (level == PW'(DEPTH));
  assign empty = (wptr == rptr);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;
  assign inc   = wr_ok && wr_last;
  assign dec   = rd_ok && rd_last;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr[AW-1:0]] <= {wr_last, wr_data};
  end

  assign {rd_last, rd_data} = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   pcnt <= pcnt + 1'b1;
        2'b01:   pcnt <= pcnt - 1'b1;
        default: pcnt <= pcnt;
      endcase
    end
  end

  assign pkt_avail = (pcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) overflow <= 1'b0;
    else if (wr_en && full) overflow <= 1'b1;
  end

  // R4: the sender never pops an empty queue
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);

  // R7: overflow flag is sticky
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R7: a write into a full queue leaves the stored level unchanged
  p_full_discard_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (level == $past(level)));

  // R3: committed packets never exceed stored quadlets
  p_pcnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    PW'(pcnt) <= level);
endmodule

// File: rtl/atxq_sender.sv
module atxq_sender
  import atxq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_Q-1:0]            q_avail,
  input  logic [NUM_Q-1:0]            q_empty,
  input  logic [NUM_Q-1:0][DATA_W-1:0] q_data,
  input  logic [NUM_Q-1:0]            q_last,
  output logic [NUM_Q-1:0]            q_pop,
  output logic                        tx_valid,
  input  logic                        tx_ready,
  output logic [DATA_W-1:0]           tx_data,
  output logic                        tx_last,
  output logic                        tx_is_rsp
);
  logic in_pkt;
  qid_e cur_q, sel_q;
  logic adv, src_ok, pop;

  assign adv = !tx_valid || tx_ready;

  always_comb begin
    if (in_pkt) begin
      sel_q  = cur_q;
      src_ok = !q_empty[cur_q];
    end else begin
      sel_q  = q_avail[Q_RSP] ? Q_RSP : Q_REQ;
      src_ok = |q_avail;
    end
  end

  assign pop = adv && src_ok;

  always_comb begin
    q_pop = '0;
    if (pop) q_pop[sel_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      tx_last   <= 1'b0;
      tx_is_rsp <= 1'b0;
      in_pkt    <= 1'b0;
      cur_q     <= Q_REQ;
    end else if (pop) begin
      tx_valid  <= 1'b1;
      tx_data   <= q_data[sel_q];
      tx_last   <= q_last[sel_q];
      tx_is_rsp <= (sel_q == Q_RSP);
      in_pkt    <= !q_last[sel_q];
      cur_q     <= sel_q;
    end else if (tx_ready) begin
      tx_valid  <= 1'b0;
    end
  end

  // R8: offered quadlet holds under backpressure
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)
                                 && $stable(tx_last) && $stable(tx_is_rsp)));

  // R6: a started packet continues back to back from the same queue
  p_no_interleave_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !tx_last) |=> (tx_valid && (tx_is_rsp == $past(tx_is_rsp))));

  // R1: at most one queue is popped per cycle
  p_single_pop_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q_pop));
endmodule

// File: rtl/atxq_top.sv
module atxq_top
  import atxq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_data,
  output logic [1:0]        pkt_ready,
  output logic [1:0]        overflow,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  output logic              tx_is_rsp
);
  logic [NUM_Q-1:0]             q_wr, q_pop, q_empty, q_full, q_avail, q_ovf, q_last;
  logic [NUM_Q-1:0][DATA_W-1:0] q_data;
  logic                         q_close;

  atxq_host_dec u_dec (
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .q_wr      (q_wr),
    .q_close   (q_close)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    atxq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (q_wr[g]),
      .wr_last   (q_close),
      .wr_data   (host_data),
      .rd_en     (q_pop[g]),
      .rd_data   (q_data[g]),
      .rd_last   (q_last[g]),
      .empty     (q_empty[g]),
      .full      (q_full[g]),
      .pkt_avail (q_avail[g]),
      .overflow  (q_ovf[g])
    );
  end

  atxq_sender #(.DATA_W(DATA_W)) u_send (
    .clk       (clk),
    .rst       (rst),
    .q_avail   (q_avail),
    .q_empty   (q_empty),
    .q_data    (q_data),
    .q_last    (q_last),
    .q_pop     (q_pop),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_is_rsp (tx_is_rsp)
  );

  assign pkt_ready = q_avail;
  assign overflow  = q_ovf;

  // R2: nothing is offered unless some packet was committed
  p_commit_first_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_valid) && !$past(tx_valid)) |-> $past(|q_avail));
endmodule

// File: tb/atxq_top_tb.sv
module atxq_top_tb;
  localparam int DW = 32;
  localparam int DEP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0;
  logic [1:0]    host_addr = 2'b00;
  logic [DW-1:0] host_data = '0;
  logic          tx_ready = 1'b0;
  logic [1:0]    pkt_ready, overflow;
  logic          tx_valid, tx_last, tx_is_rsp;
  logic [DW-1:0] tx_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  atxq_top #(.DATA_W(DW), .DEPTH(DEP)) u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_data(host_data), .pkt_ready(pkt_ready), .overflow(overflow),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_is_rsp(tx_is_rsp)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pd(input int q, input int len, input int idx);
    return {(q != 0) ? 8'hC3 : 8'h3C, 8'(len), 16'(idx + 16'h0100)};
  endfunction

  task automatic hw(input int q, input bit close, input logic [DW-1:0] d);
    host_wr = 1'b1;
    host_addr = {q[0], close};
    host_data = d;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic put_pkt(input int q, input int len);
    for (int i = 0; i < len; i++) hw(q, i == len - 1, pd(q, len, i));
  endtask

  // waits for an offered quadlet, compares it, and consumes it (tx_ready must be 1)
  task automatic expect_beat(input logic [DW-1:0] d, input bit last, input bit rsp, input string rq);
    for (int i = 0; i < 40 && !tx_valid; i++) @(negedge clk);
    chk(tx_valid, {rq, " valid"}, DW'(tx_valid), 1);
    chk(tx_data == d, {rq, " data"}, tx_data, d);
    chk(tx_last == last, "R4 last", DW'(tx_last), DW'(last));
    chk(tx_is_rsp == rsp, "R1 queue", DW'(tx_is_rsp), DW'(rsp));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_pkt(input int q, input int len, input string rq);
    for (int i = 0; i < len; i++) expect_beat(pd(q, len, i), i == len - 1, q != 0, rq);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk(!tx_valid, "R9 tx_valid", DW'(tx_valid), 0);
    chk(pkt_ready == 2'b00, "R9 pkt_ready", DW'(pkt_ready), 0);
    chk(overflow == 2'b00, "R9 overflow", DW'(overflow), 0);

    // sweep: packet lengths 1..6 on both queues
    tx_ready = 1'b1;
    for (int len = 1; len <= 6; len++) begin
      for (int q = 0; q < 2; q++) begin
        put_pkt(q, len);
        chk(pkt_ready == 2'(1 << q), "R3 ready after close", DW'(pkt_ready), DW'(1 << q));
        chk(!tx_valid, "R3 not yet offered", DW'(tx_valid), 0);
        expect_pkt(q, len, "R4 sweep");
        chk(pkt_ready == 2'b00, "R9 ready cleared", DW'(pkt_ready), 0);
        chk(!tx_valid, "R4 no extra beat", DW'(tx_valid), 0);
      end
    end

    // R2: append-only writes commit nothing
    for (int i = 0; i < 3; i++) hw(0, 1'b0, pd(0, 4, i));
    repeat (5) @(negedge clk);
    chk(!tx_valid, "R2 no valid", DW'(tx_valid), 0);
    chk(pkt_ready == 2'b00, "R2 no ready", DW'(pkt_ready), 0);
    hw(0, 1'b1, pd(0, 4, 3));
    expect_pkt(0, 4, "R2 closed later");

    // R5: response goes first at a boundary
    tx_ready = 1'b0;
    put_pkt(0, 1);
    put_pkt(0, 2);
    put_pkt(1, 2);
    @(negedge clk);
    tx_ready = 1'b1;
    expect_pkt(0, 1, "R5 held");
    expect_pkt(1, 2, "R5 rsp first");
    expect_pkt(0, 2, "R5 req after");

    // R6: started request packet is not interrupted
    tx_ready = 1'b0;
    put_pkt(0, 3);
    put_pkt(1, 1);
    @(negedge clk);
    tx_ready = 1'b1;
    expect_pkt(0, 3, "R6 req whole");
    expect_pkt(1, 1, "R6 rsp after");

    // R7/R8: overflow with backpressure
    tx_ready = 1'b0;
    put_pkt(1, 1);
    @(negedge clk);
    put_pkt(0, DEP);
    hw(0, 1'b0, 32'hDEAD_BEEF);
    chk(overflow == 2'b01, "R7 overflow req only", DW'(overflow), 1);
    for (int i = 0; i < 3; i++) begin
      chk(tx_valid && tx_data == pd(1, 1, 0) && tx_is_rsp, "R8 hold", tx_data, pd(1, 1, 0));
      @(negedge clk);
    end
    tx_ready = 1'b1;
    expect_pkt(1, 1, "R8 released");
    expect_pkt(0, DEP, "R7 full pkt");
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R7 dropped write absent", DW'(tx_valid), 0);
    chk(overflow == 2'b01, "R7 sticky", DW'(overflow), 1);

    summary();
  end
endmodule